// File: doc/BRIEF.md
# Video timing generator

This block produces the horizontal sync, vertical sync and data-enable timing for a video-mode display link, and it forms the outgoing pixel stream. A frame counter advances once per pixel clock from zero to the programmed frame length. A line counter runs beside it and is cleared at every frame start. Every vertical boundary (vsync width, display window, active sub-window) is programmed as an absolute pixel-clock offset inside the frame. Software therefore folds the line period and any sync skew into those numbers, and the hardware needs only one comparator per boundary.

Pixels come in over a valid/ready handshake. Ready is raised only for positions inside the active sub-window. Display-window positions outside that sub-window show a programmable border colour. When a pixel is missing, the position shows a programmable underflow colour. If recovery is enabled, the block stops fetching for the rest of that frame and shows the underflow colour until the next frame starts. A sticky flag records that an underflow happened. Configuration is written through a simple word-addressed write port.

Top module: `video_timing_gen`

## Requirements
- R1: While reset is held, and in the cycle after it, hsync_o, vsync_o, de_o, pix_o, frame_done_o, underflow_o and pix_ready are all 0.
- R2: Writing 1 to bit 0 of address 0 starts the generator. The frame position is 0 in the cycle after the write takes effect. Every output other than pix_ready is registered and reflects a position one cycle after that position.
- R3: The frame position counts from 0 to (address 2, bits 30:0) minus 1 and then wraps. The line position counts from 0 to (address 1, bits 31:16) minus 1 and restarts at every frame start. frame_done_o is high for exactly the one output cycle that belongs to the last frame position.
- R4: Address 1 holds the line period in bits 31:16 and the hsync width in bits 15:0. Address 12 bits 15:0 hold the skew. Raw hsync is high while the line position lies in [skew, skew + width).
- R5: Raw vsync is high while the frame position is below address 3 (bits 30:0, in pixel clocks).
- R6: Address 4 holds the display last column in bits 31:16 and the first column in bits 15:0. Addresses 5 and 6 hold the first and last frame positions of the display window. de is high inside both ranges, inclusive. pix_o is 0 outside the window.
- R7: Address 7 holds the sub-window enable in bit 31, the last column in bits 30:16 and the first column in bits 15:0. Address 8 holds the enable in bit 31 and the first frame position in bits 30:0. Address 9 holds the last frame position. A dimension whose enable is 0 follows the display window. Display positions outside the sub-window show the border colour from address 10.
- R8: pix_ready is high exactly when the generator runs, the position is inside the sub-window and no recovery hold is active. A pixel taken on a handshake appears on pix_o in the next cycle.
- R9: Address 11 holds the underflow colour in its low bits and the recovery enable in bit 31. With recovery off, a position whose pixel is missing shows the underflow colour, and the next positions fetch normally.
- R10: With recovery on, a missing pixel drops pix_ready and forces the underflow colour for every remaining sub-window position of that frame. Fetching resumes at frame position 0.
- R11: underflow_o goes high in the output cycle of the first missing pixel and stays high. A write to address 14 clears it in the same edge, and a new miss in that same cycle wins.
- R12: Address 13 bits 0, 1 and 2 invert hsync_o, vsync_o and de_o respectively, both while running and while idle. All three reset to 0.
- R13: Clearing bit 0 of address 0 mid-frame lets the current frame run to its last position. The generator then goes idle at frame position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| pix_valid | input | 1 | Source pixel present |
| pix_data | input | PIX_W | Source pixel value |
| pix_ready | output | 1 | Pixel taken this cycle when valid |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_o | output | PIX_W | Output pixel, border or underflow colour |
| frame_done_o | output | 1 | One-cycle pulse for the last frame position |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The counters reach frame position 0 one edge after the enable write lands. Sync, enable, pixel, frame-done and flag outputs follow one further edge later, while pix_ready is combinational on the current position. The bench therefore keeps a position model. At each falling edge it compares pix_ready with the position it has just advanced to, and it compares the registered outputs with the expectation it stored one iteration earlier. A stop request only changes the model when that model's frame wraps, and an underflow hold is set one position after the miss. This mirrors the edge at which the design's registers take each event.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

   localparam int unsigned REG_AW = 4;
   localparam int unsigned REG_DW = 32;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL    = 4'd0,
      RA_HTIME   = 4'd1,
      RA_FRAME   = 4'd2,
      RA_VPULSE  = 4'd3,
      RA_DISP_H  = 4'd4,
      RA_DISP_VF = 4'd5,
      RA_DISP_VL = 4'd6,
      RA_ACT_H   = 4'd7,
      RA_ACT_VF  = 4'd8,
      RA_ACT_VL  = 4'd9,
      RA_BORDER  = 4'd10,
      RA_UFLOW   = 4'd11,
      RA_SKEW    = 4'd12,
      RA_POL     = 4'd13,
      RA_CLEAR   = 4'd14
   } vtg_reg_e;

   typedef struct packed {
      logic        run_req;
      logic [15:0] h_period;
      logic [15:0] h_pulse;
      logic [15:0] h_skew;
      logic [15:0] dh_first;
      logic [15:0] dh_last;
      logic        ah_en;
      logic [15:0] ah_first;
      logic [15:0] ah_last;
      logic [30:0] frame_len;
      logic [30:0] v_pulse;
      logic [30:0] dv_first;
      logic [30:0] dv_last;
      logic        av_en;
      logic [30:0] av_first;
      logic [30:0] av_last;
      logic [30:0] border_col;
      logic [30:0] uflow_col;
      logic        uf_recover;
      logic [2:0]  pol_inv;
   } vtg_cfg_t;

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
   import vtg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [REG_DW-1:0] wr_data,
   output vtg_cfg_t          cfg,
   output logic              stat_clr
);

   vtg_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            RA_CTRL:    cfg_q.run_req <= wr_data[0];
            RA_HTIME: begin
               cfg_q.h_period <= wr_data[31:16];
               cfg_q.h_pulse  <= wr_data[15:0];
            end
            RA_FRAME:   cfg_q.frame_len <= wr_data[30:0];
            RA_VPULSE:  cfg_q.v_pulse   <= wr_data[30:0];
            RA_DISP_H: begin
               cfg_q.dh_last  <= wr_data[31:16];
               cfg_q.dh_first <= wr_data[15:0];
            end
            RA_DISP_VF: cfg_q.dv_first <= wr_data[30:0];
            RA_DISP_VL: cfg_q.dv_last  <= wr_data[30:0];
            RA_ACT_H: begin
               cfg_q.ah_en    <= wr_data[31];
               cfg_q.ah_last  <= {1'b0, wr_data[30:16]};
               cfg_q.ah_first <= wr_data[15:0];
            end
            RA_ACT_VF: begin
               cfg_q.av_en    <= wr_data[31];
               cfg_q.av_first <= wr_data[30:0];
            end
            RA_ACT_VL:  cfg_q.av_last    <= wr_data[30:0];
            RA_BORDER:  cfg_q.border_col <= wr_data[30:0];
            RA_UFLOW: begin
               cfg_q.uf_recover <= wr_data[31];
               cfg_q.uflow_col  <= wr_data[30:0];
            end
            RA_SKEW:    cfg_q.h_skew  <= wr_data[15:0];
            RA_POL:     cfg_q.pol_inv <= wr_data[2:0];
            default: ;
         endcase
      end
   end

   assign cfg      = cfg_q;
   assign stat_clr = wr_en && (wr_addr == RA_CLEAR);

endmodule

// File: rtl/vtg_counters.sv
module vtg_counters #(
   parameter int unsigned CNT_W = 24,
   parameter int unsigned H_W   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_req,
   input  logic [CNT_W-1:0] frame_len,
   input  logic [H_W-1:0]   h_period,
   output logic             running,
   output logic [CNT_W-1:0] fpos,
   output logic [H_W-1:0]   hpos,
   output logic             frame_last
);

   localparam logic [CNT_W-1:0] F_ONE = CNT_W'(1);
   localparam logic [H_W-1:0]   H_ONE = H_W'(1);

   logic line_last;

   assign frame_last = running && (fpos == frame_len - F_ONE);
   assign line_last  = (hpos == h_period - H_ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         fpos    <= '0;
         hpos    <= '0;
      end else if (!running) begin
         fpos <= '0;
         hpos <= '0;
         if (run_req) running <= 1'b1;
      end else if (frame_last) begin
         fpos <= '0;
         hpos <= '0;
         if (!run_req) running <= 1'b0;
      end else begin
         fpos <= fpos + F_ONE;
         hpos <= line_last ? '0 : hpos + H_ONE;
      end
   end

endmodule

// File: rtl/vtg_span.sv
module vtg_span #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] pos,
   input  logic [W-1:0] first,
   input  logic [W-1:0] last,
   output logic         hit
);

   assign hit = (pos >= first) && (pos <= last);

endmodule

// File: rtl/vtg_pixel.sv
module vtg_pixel #(
   parameter int unsigned PIX_W   = 24,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             running,
   input  logic             in_disp,
   input  logic             in_act,
   input  logic             hs_raw,
   input  logic             vs_raw,
   input  logic             frame_last,
   input  logic             recover,
   input  logic             stat_clr,
   input  logic [2:0]       pol_inv,
   input  logic [PIX_W-1:0] border_col,
   input  logic [PIX_W-1:0] uflow_col,
   input  logic             src_valid,
   input  logic [PIX_W-1:0] src_data,
   output logic             src_ready,
   output logic             hold_o,
   output logic             hs_o,
   output logic             vs_o,
   output logic             de_o,
   output logic             done_o,
   output logic [PIX_W-1:0] pix_o,
   output logic             uf_flag_o
);

   logic             hold_q;
   logic             sticky_q;
   logic             miss;
   logic [PIX_W-1:0] pix_d;
   logic             hs_d, vs_d, de_d, done_d;

   assign src_ready = running && in_act && !hold_q;
   assign miss      = src_ready && !src_valid;

   always_ff @(posedge clk) begin
      if (!rst_n)                     hold_q <= 1'b0;
      else if (!running || frame_last) hold_q <= 1'b0;
      else if (miss && recover)       hold_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        sticky_q <= 1'b0;
      else if (miss)     sticky_q <= 1'b1;
      else if (stat_clr) sticky_q <= 1'b0;
   end

   always_comb begin
      if (!running || !in_disp)      pix_d = '0;
      else if (!in_act)              pix_d = border_col;
      else if (src_ready && src_valid) pix_d = src_data;
      else                           pix_d = uflow_col;
   end

   assign hs_d   = (running && hs_raw)  ^ pol_inv[0];
   assign vs_d   = (running && vs_raw)  ^ pol_inv[1];
   assign de_d   = (running && in_disp) ^ pol_inv[2];
   assign done_d = frame_last;

   generate
      if (OUT_REG) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hs_o   <= 1'b0;
               vs_o   <= 1'b0;
               de_o   <= 1'b0;
               done_o <= 1'b0;
               pix_o  <= '0;
            end else begin
               hs_o   <= hs_d;
               vs_o   <= vs_d;
               de_o   <= de_d;
               done_o <= done_d;
               pix_o  <= pix_d;
            end
         end
      end else begin : g_out_comb
         assign hs_o   = hs_d;
         assign vs_o   = vs_d;
         assign de_o   = de_d;
         assign done_o = done_d;
         assign pix_o  = pix_d;
      end
   endgenerate

   assign hold_o    = hold_q;
   assign uf_flag_o = sticky_q;

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
   import vtg_pkg::*;
#(
   parameter int unsigned PIX_W      = 24,
   parameter int unsigned CNT_W      = 24,
   parameter int unsigned H_W        = 16,
   parameter bit          HAS_SUBWIN = 1'b1,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [REG_AW-1:0] cfg_addr,
   input  logic [REG_DW-1:0] cfg_wdata,
   input  logic              pix_valid,
   input  logic [PIX_W-1:0]  pix_data,
   output logic              pix_ready,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic [PIX_W-1:0]  pix_o,
   output logic              frame_done_o,
   output logic              underflow_o
);

   generate
      if (PIX_W < 1 || PIX_W > 31) begin : g_bad_pix
         $error("PIX_W must lie in 1..31");
      end
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
         $error("CNT_W must lie in 2..31");
      end
      if (H_W < 2 || H_W > 16) begin : g_bad_h
         $error("H_W must lie in 2..16");
      end
   endgenerate

   vtg_cfg_t cfg;
   logic     stat_clr;
   logic     unused_cfg;

   assign unused_cfg = ^cfg;

   vtg_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .cfg      (cfg),
      .stat_clr (stat_clr)
   );

   logic             running;
   logic             frame_last;
   logic [CNT_W-1:0] fpos;
   logic [H_W-1:0]   hpos;
   logic [CNT_W-1:0] frame_len_w;
   logic             run_req;

   assign frame_len_w = cfg.frame_len[CNT_W-1:0];
   assign run_req     = cfg.run_req;

   vtg_counters #(.CNT_W(CNT_W), .H_W(H_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_req    (run_req),
      .frame_len  (frame_len_w),
      .h_period   (cfg.h_period[H_W-1:0]),
      .running    (running),
      .fpos       (fpos),
      .hpos       (hpos),
      .frame_last (frame_last)
   );

   // sync strobes
   logic [H_W-1:0] skew_w;
   logic [H_W:0]   hs_end;
   logic           hs_raw, vs_raw;

   assign skew_w = cfg.h_skew[H_W-1:0];
   assign hs_end = {1'b0, skew_w} + {1'b0, cfg.h_pulse[H_W-1:0]};
   assign hs_raw = (hpos >= skew_w) && ({1'b0, hpos} < hs_end);
   assign vs_raw = (fpos < cfg.v_pulse[CNT_W-1:0]);

   // display window
   logic dh_hit, dv_hit, in_disp, in_act;

   vtg_span #(.W(H_W)) u_disp_h (
      .pos (hpos),
      .first (cfg.dh_first[H_W-1:0]),
      .last  (cfg.dh_last[H_W-1:0]),
      .hit (dh_hit)
   );

   vtg_span #(.W(CNT_W)) u_disp_v (
      .pos (fpos),
      .first (cfg.dv_first[CNT_W-1:0]),
      .last  (cfg.dv_last[CNT_W-1:0]),
      .hit (dv_hit)
   );

   assign in_disp = dh_hit && dv_hit;

   generate
      if (HAS_SUBWIN) begin : g_subwin
         logic ah_hit, av_hit;

         vtg_span #(.W(H_W)) u_act_h (
            .pos (hpos),
            .first (cfg.ah_first[H_W-1:0]),
            .last  (cfg.ah_last[H_W-1:0]),
            .hit (ah_hit)
         );

         vtg_span #(.W(CNT_W)) u_act_v (
            .pos (fpos),
            .first (cfg.av_first[CNT_W-1:0]),
            .last  (cfg.av_last[CNT_W-1:0]),
            .hit (av_hit)
         );

         assign in_act = in_disp
                       && (cfg.ah_en ? ah_hit : 1'b1)
                       && (cfg.av_en ? av_hit : 1'b1);
      end else begin : g_no_subwin
         assign in_act = in_disp;
      end
   endgenerate

   logic           uf_hold;
   logic [2:0]     pol_w;

   assign pol_w = cfg.pol_inv;

   vtg_pixel #(.PIX_W(PIX_W), .OUT_REG(OUT_REG)) u_pix (
      .clk        (clk),
      .rst_n      (rst_n),
      .running    (running),
      .in_disp    (in_disp),
      .in_act     (in_act),
      .hs_raw     (hs_raw),
      .vs_raw     (vs_raw),
      .frame_last (frame_last),
      .recover    (cfg.uf_recover),
      .stat_clr   (stat_clr),
      .pol_inv    (pol_w),
      .border_col (cfg.border_col[PIX_W-1:0]),
      .uflow_col  (cfg.uflow_col[PIX_W-1:0]),
      .src_valid  (pix_valid),
      .src_data   (pix_data),
      .src_ready  (pix_ready),
      .hold_o     (uf_hold),
      .hs_o       (hsync_o),
      .vs_o       (vsync_o),
      .de_o       (de_o),
      .done_o     (frame_done_o),
      .pix_o      (pix_o),
      .uf_flag_o  (underflow_o)
   );

endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
   parameter int unsigned CNT_W   = 24,
   parameter bit          OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_req,
   input logic             running,
   input logic             frame_last,
   input logic [CNT_W-1:0] fpos,
   input logic             uf_hold,
   input logic             stat_clr,
   input logic [2:0]       pol_w,
   input logic             pix_ready,
   input logic             de_o,
   input logic             frame_done_o,
   input logic             underflow_o
);

   AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !pix_ready); // R8

   AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (run_req && !running) |=> (running && fpos == '0)); // R2

   AST_RUN_TILL_END: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !frame_last) |=> running); // R13

   AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      uf_hold |-> !pix_ready); // R10

   AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_last |=> !uf_hold); // R10

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow_o && !stat_clr) |=> underflow_o); // R11

   generate
      if (OUT_REG) begin : g_reg_checks
         AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
            frame_last |=> frame_done_o); // R3

         AST_IDLE_DE_POL: assert property (@(posedge clk) disable iff (!rst_n)
            !running |=> (de_o == $past(pol_w[2]))); // R12
      end
   endgenerate

endmodule

bind video_timing_gen vtg_checker #(.CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_vtg_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_req      (run_req),
   .running      (running),
   .frame_last   (frame_last),
   .fpos         (fpos),
   .uf_hold      (uf_hold),
   .stat_clr     (stat_clr),
   .pol_w        (pol_w),
   .pix_ready    (pix_ready),
   .de_o         (de_o),
   .frame_done_o (frame_done_o),
   .underflow_o  (underflow_o)
);

// File: tb/video_timing_gen_bench.sv
module video_timing_gen_bench;

   localparam int PW     = 24;
   localparam int HPER   = 10;
   localparam int FLEN   = 60;
   localparam int BORDER = 'hB0B0B0;
   localparam int UCOL   = 'h00FF00;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          pix_valid = 1'b0;
   logic [PW-1:0] pix_data = '0;
   logic          pix_ready, hsync_o, vsync_o, de_o, frame_done_o, underflow_o;
   logic [PW-1:0] pix_o;

   always #10 clk = ~clk;

   video_timing_gen u_video_timing_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we),
      .cfg_addr     (cfg_addr),
      .cfg_wdata    (cfg_wdata),
      .pix_valid    (pix_valid),
      .pix_data     (pix_data),
      .pix_ready    (pix_ready),
      .hsync_o      (hsync_o),
      .vsync_o      (vsync_o),
      .de_o         (de_o),
      .pix_o        (pix_o),
      .frame_done_o (frame_done_o),
      .underflow_o  (underflow_o)
   );

   int n_vec = 0;
   int n_bad = 0;
   int seq   = 'h100;

   bit       m_act_en = 0;
   bit       m_rec    = 0;
   bit [2:0] m_pol    = 3'b000;
   bit       e_stk    = 0;

   bit       e_hs, e_vs, e_de, e_done, e_uf;
   int       e_pix;

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_addr  = addr[3:0];
      cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (addr == 14) e_stk = 0;
   endtask

   task automatic check_outputs();
      chk("R4 R12", "hsync", int'(hsync_o), int'(e_hs));
      chk("R5 R12", "vsync", int'(vsync_o), int'(e_vs));
      chk("R6 R12", "de", int'(de_o), int'(e_de));
      chk("R7 R8 R9 R10", "pixel", int'(pix_o), e_pix);
      chk("R3", "frame_done", int'(frame_done_o), int'(e_done));
      chk("R11", "underflow", int'(underflow_o), int'(e_uf));
   endtask

   task automatic set_idle_expect();
      e_hs = m_pol[0]; e_vs = m_pol[1]; e_de = m_pol[2];
      e_pix = 0; e_done = 0; e_uf = e_stk;
   endtask

   // ncyc positions, stop request at index stop_at, gaps selects missing pixels
   task automatic run_phase(input int ncyc, input int stop_at, input bit gaps);
      bit mrun = 1;
      bit hold = 0;
      bit stopreq = 0;
      int f = 0;
      set_idle_expect();
      for (int k = 0; k < ncyc; k++) begin
         int  h;
         bit  dsp, act, hr, vr, rdy, vld, miss;
         @(negedge clk);
         check_outputs();
         if (k == stop_at) begin
            cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 0; stopreq = 1;
         end else begin
            cfg_we = 1'b0;
         end
         h   = f % HPER;
         dsp = mrun && h >= 3 && h <= 8 && f >= 21 && f <= 50;
         act = dsp && (!m_act_en || (h >= 4 && h <= 7 && f >= 31 && f <= 50));
         hr  = mrun && h >= 1 && h < 3;
         vr  = mrun && f < 10;
         rdy = mrun && act && !hold;
         chk("R8", "ready", int'(pix_ready), int'(rdy));
         vld = !(gaps && (k % 7) == 3);
         pix_valid = vld;
         pix_data  = seq[PW-1:0];
         miss = rdy && !vld;
         e_hs = hr ^ m_pol[0];
         e_vs = vr ^ m_pol[1];
         e_de = dsp ^ m_pol[2];
         if (!dsp)            e_pix = 0;
         else if (!act)       e_pix = BORDER;
         else if (rdy && vld) e_pix = seq;
         else                 e_pix = UCOL;
         e_done = mrun && f == FLEN - 1;
         if (miss) e_stk = 1;
         e_uf = e_stk;
         if (rdy && vld) seq++;
         if (!mrun || f == FLEN - 1) hold = 0;
         else if (miss && m_rec)     hold = 1;
         if (mrun) begin
            if (f == FLEN - 1) begin
               f = 0;
               if (stopreq) mrun = 0;
            end else begin
               f++;
            end
         end
      end
      @(negedge clk);
      check_outputs();
      cfg_we = 1'b0;
      pix_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "hsync", int'(hsync_o), 0);
      chk("R1", "de", int'(de_o), 0);
      chk("R1", "pixel", int'(pix_o), 0);
      chk("R1", "ready", int'(pix_ready), 0);
      chk("R1", "underflow", int'(underflow_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "frame_done", int'(frame_done_o), 0);
      chk("R1", "vsync", int'(vsync_o), 0);

      wr(1, (HPER << 16) | 2);
      wr(2, FLEN);
      wr(3, 10);
      wr(4, (8 << 16) | 3);
      wr(5, 21);
      wr(6, 50);
      wr(7, 0);
      wr(8, 0);
      wr(9, 50);
      wr(10, BORDER);
      wr(11, UCOL);
      wr(12, 1);
      wr(13, 0);

      // R2 R3 R13: full window, steady source, stop mid second frame
      wr(0, 1);
      run_phase(135, 70, 1'b0);

      // R7 R9 R11: sub-window, border, missing pixels without recovery
      wr(7, 32'h8000_0000 | (7 << 16) | 4);
      wr(8, 32'h8000_0000 | 31);
      m_act_en = 1;
      wr(0, 1);
      run_phase(135, 75, 1'b1);

      // R11 clear of the sticky flag
      wr(14, 0);
      chk("R11", "underflow after clear", int'(underflow_o), 0);

      // R10 R12: recovery hold with all polarities inverted
      wr(11, 32'h8000_0000 | UCOL);
      m_rec = 1;
      wr(13, 7);
      m_pol = 3'b111;
      wr(0, 1);
      run_phase(135, 72, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule